// File: doc/BRIEF.md
# Tag-Flag Instruction Execute Unit

This unit decodes and executes a small group of tag-related instructions from a 32-bit instruction word. Bits are numbered MSB-first, so bit 0 is `instr_i[31]` and bit 31 is `instr_i[0]`. The group has three members:

- A set-tag instruction, which raises the tag flag in the 64-bit fixed-point exception register (XER).
- A trap-on-flag instruction, which asks for a trap when a chosen XER bit is clear.
- Four select instructions. Each writes one of two operands to a register, depending on a chosen XER bit. Dotted forms also produce a condition field.

When the tags-active mode bit is low, every instruction in the group is reported as illegal and has no other effect. Instructions outside the group produce no outputs, so other units can execute them.

The unit sits beside the register file. It drives the two read addresses combinationally and takes the read data back in the same cycle. All results are registered and come out one cycle later as single-cycle strobes. The owner of the XER commits `xer_o` when `xer_we_o` is high.

Top module: `tagx_exec`

## Requirements
- R1: While `rst` is high, all strobes (`wr_en_o`, `cr_we_o`, `xer_we_o`, `trap_o`, `illegal_o`) and `result_o` are zero on the following clock edge.
- R2: In tags-active mode, the word 32'h7C0103E6 sets `xer_we_o`, with `xer_o` equal to `xer_i` and bit 20 (LSB-numbered; the tag flag) forced to 1. No register write occurs.
- R3: A select instruction has primary opcode 30 in `instr_i[31:26]` and minor code 24..31 in `instr_i[4:0]`. It writes to register `instr_i[20:16]`. The value is operand A when the tested XER bit is 1 and operand B when it is 0. The tested bit is LSB index 31−k, where k = `instr_i[10:7]`, so k=11 tests the tag flag.
- R4: Operand A comes from field `instr_i[25:21]` and operand B from field `instr_i[15:11]`. Minor 24/25 use immediate/immediate, 26/27 use immediate/register, 28/29 use register/immediate, and 30/31 use register/register. An immediate is the 5-bit field sign-extended. A register operand is read at the address equal to its field, which `ra_addr_o` and `rb_addr_o` present.
- R5: An odd minor code (the dotted form) also asserts `cr_we_o`. `cr_o` is {negative, positive, zero, SO}, where the first three compare the result as a signed value and SO is XER bit 31 (LSB-numbered). Even minor codes leave `cr_we_o` low.
- R6: Trap-on-flag has primary opcode 31 and minor code 36 in `instr_i[6:1]`. It asserts `trap_o` when the XER bit selected by k = `instr_i[10:7]` is 0, and writes nothing.
- R7: With tags-active low, any instruction in the group asserts `illegal_o` only, with no write, condition, XER or trap strobe.
- R8: Words outside the group, or cycles with `valid_i` low, produce no strobe.
- R9: Every output appears exactly one clock edge after the instruction is presented, and the strobes last for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| tags_active_i | input | 1 | Tags-active mode bit |
| xer_i | input | 64 | Current exception register |
| ra_addr_o | output | 5 | Register read address for operand A |
| rb_addr_o | output | 5 | Register read address for operand B |
| ra_data_i | input | 64 | Read data for operand A |
| rb_data_i | input | 64 | Read data for operand B |
| result_o | output | 64 | Select result |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | 5 | Register write address |
| cr_we_o | output | 1 | Condition-field update strobe |
| cr_o | output | 4 | Condition field {neg, pos, zero, SO} |
| xer_we_o | output | 1 | Exception register update strobe |
| xer_o | output | 64 | New exception register value |
| trap_o | output | 1 | Trap request |
| illegal_o | output | 1 | Illegal-instruction flag |

## Verification
The read addresses are combinational and are checked in the same cycle that the word is driven. The result, write address, condition field, XER update, trap and illegal flag all come from a single register stage, so each of them is due one clock edge after the instruction is presented. The bench drives inputs on the falling edge and samples outputs on the next falling edge, which is half a cycle after the capturing edge. It then drops `valid_i` and samples once more to confirm that every strobe has cleared.

// File: rtl/tagx_pkg.sv
package tagx_pkg;

    localparam int XLEN       = 64;
    localparam int IW         = 32;
    localparam int RADDR_W    = 5;
    localparam int IMM_W      = 5;
    localparam int SELK_W     = 4;
    localparam int CR_W       = 4;
    localparam int TAG_LSB    = 20;
    localparam int SO_LSB     = 31;
    localparam int XIDX_W     = $clog2(XLEN);

    localparam logic [5:0]    OP_SEL      = 6'd30;
    localparam logic [5:0]    OP_X        = 6'd31;
    localparam logic [5:0]    XO_TRAP     = 6'd36;
    localparam logic [IW-1:0] SETTAG_WORD = 32'h7C01_03E6;

    typedef enum logic [1:0] {
        K_NONE,
        K_SETTAG,
        K_TRAP,
        K_SEL
    } kind_e;

    typedef struct packed {
        kind_e                kind;
        logic                 a_is_reg;
        logic                 b_is_reg;
        logic                 dot;
        logic [RADDR_W-1:0]   rt;
        logic [RADDR_W-1:0]   fa;
        logic [RADDR_W-1:0]   fb;
        logic [SELK_W-1:0]    k;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0]      value;
        logic [CR_W-1:0]      cr;
        logic                 flag;
    } exu_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] f);
        return {{(XLEN-IMM_W){f[IMM_W-1]}}, f};
    endfunction

    function automatic logic [XIDX_W-1:0] xer_index(input logic [SELK_W-1:0] k);
        return XIDX_W'(SO_LSB) - XIDX_W'(k);
    endfunction

endpackage

// File: rtl/tagx_decode.sv
module tagx_decode
    import tagx_pkg::*;
(
    input  logic          valid_i,
    input  logic [IW-1:0] instr_i,
    output dec_t          dec_o
);
    logic [5:0] prim;
    logic [4:0] sel_minor;
    logic [5:0] x_minor;
    logic       is_sel;
    logic       is_trap;
    logic       is_set;

    always_comb begin
        prim      = instr_i[31:26];
        sel_minor = instr_i[4:0];
        x_minor   = instr_i[6:1];
        is_set    = (instr_i == SETTAG_WORD);
        is_trap   = !is_set && (prim == OP_X) && (x_minor == XO_TRAP);
        is_sel    = (prim == OP_SEL) && (sel_minor[4:3] == 2'b11);

        dec_o          = '0;
        dec_o.kind     = K_NONE;
        dec_o.rt       = instr_i[20:16];
        dec_o.fa       = instr_i[25:21];
        dec_o.fb       = instr_i[15:11];
        dec_o.k        = instr_i[10:7];
        dec_o.dot      = sel_minor[0];
        dec_o.a_is_reg = sel_minor[2];
        dec_o.b_is_reg = sel_minor[1];
        if (valid_i) begin
            if (is_set)       dec_o.kind = K_SETTAG;
            else if (is_trap) dec_o.kind = K_TRAP;
            else if (is_sel)  dec_o.kind = K_SEL;
        end
    end
endmodule

// File: rtl/tagx_operand.sv
module tagx_operand
    import tagx_pkg::*;
(
    input  logic               is_reg_i,
    input  logic [IMM_W-1:0]   field_i,
    input  logic [XLEN-1:0]    rdata_i,
    output logic [XLEN-1:0]    value_o
);
    always_comb begin
        value_o = is_reg_i ? rdata_i : sext_imm(field_i);
    end
endmodule

// File: rtl/tagx_select.sv
module tagx_select
    import tagx_pkg::*;
(
    input  dec_t               dec_i,
    input  logic [XLEN-1:0]    xer_i,
    input  logic [XLEN-1:0]    ra_data_i,
    input  logic [XLEN-1:0]    rb_data_i,
    output exu_t               exu_o
);
    localparam int NOPND = 2;

    logic [XLEN-1:0] opnd [NOPND];
    logic            pick_reg [NOPND];
    logic [IMM_W-1:0] pick_fld [NOPND];
    logic [XLEN-1:0] pick_dat [NOPND];

    always_comb begin
        pick_reg[0] = dec_i.a_is_reg;
        pick_reg[1] = dec_i.b_is_reg;
        pick_fld[0] = dec_i.fa;
        pick_fld[1] = dec_i.fb;
        pick_dat[0] = ra_data_i;
        pick_dat[1] = rb_data_i;
    end

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        tagx_operand u_opnd (
            .is_reg_i (pick_reg[g]),
            .field_i  (pick_fld[g]),
            .rdata_i  (pick_dat[g]),
            .value_o  (opnd[g])
        );
    end

    logic            tested;
    logic [XLEN-1:0] chosen;
    logic            neg, zer;

    always_comb begin
        tested     = xer_i[xer_index(dec_i.k)];
        chosen     = tested ? opnd[0] : opnd[1];
        neg        = chosen[XLEN-1];
        zer        = (chosen == '0);
        exu_o.value = chosen;
        exu_o.cr    = {neg, !neg && !zer, zer, xer_i[SO_LSB]};
        exu_o.flag  = tested;
    end
endmodule

// File: rtl/tagx_exec.sv
module tagx_exec
    import tagx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                valid_i,
    input  logic [IW-1:0]       instr_i,
    input  logic                tags_active_i,
    input  logic [XLEN-1:0]     xer_i,
    output logic [RADDR_W-1:0]  ra_addr_o,
    output logic [RADDR_W-1:0]  rb_addr_o,
    input  logic [XLEN-1:0]     ra_data_i,
    input  logic [XLEN-1:0]     rb_data_i,
    output logic [XLEN-1:0]     result_o,
    output logic                wr_en_o,
    output logic [RADDR_W-1:0]  wr_addr_o,
    output logic                cr_we_o,
    output logic [CR_W-1:0]     cr_o,
    output logic                xer_we_o,
    output logic [XLEN-1:0]     xer_o,
    output logic                trap_o,
    output logic                illegal_o
);
    localparam logic [XLEN-1:0] TAG_MASK = XLEN'(1) << TAG_LSB;

    dec_t dec;
    exu_t exu;

    tagx_decode u_dec (
        .valid_i (valid_i),
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    tagx_select u_sel (
        .dec_i     (dec),
        .xer_i     (xer_i),
        .ra_data_i (ra_data_i),
        .rb_data_i (rb_data_i),
        .exu_o     (exu)
    );

    assign ra_addr_o = dec.fa;
    assign rb_addr_o = dec.fb;

    logic known, do_sel, do_set, do_trap;

    always_comb begin
        known   = (dec.kind != K_NONE);
        do_sel  = tags_active_i && (dec.kind == K_SEL);
        do_set  = tags_active_i && (dec.kind == K_SETTAG);
        do_trap = tags_active_i && (dec.kind == K_TRAP) && !exu.flag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o  <= '0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            cr_we_o   <= 1'b0;
            cr_o      <= '0;
            xer_we_o  <= 1'b0;
            xer_o     <= '0;
            trap_o    <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            result_o  <= do_sel ? exu.value : '0;
            wr_en_o   <= do_sel;
            wr_addr_o <= do_sel ? dec.rt : '0;
            cr_we_o   <= do_sel && dec.dot;
            cr_o      <= (do_sel && dec.dot) ? exu.cr : '0;
            xer_we_o  <= do_set;
            xer_o     <= do_set ? (xer_i | TAG_MASK) : '0;
            trap_o    <= do_trap;
            illegal_o <= known && !tags_active_i;
        end
    end
endmodule

// File: rtl/tagx_exec_chk.sv
module tagx_exec_chk
    import tagx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_i,
    input  logic               tags_active_i,
    input  logic [XLEN-1:0]    result_o,
    input  logic               wr_en_o,
    input  logic               cr_we_o,
    input  logic               xer_we_o,
    input  logic [XLEN-1:0]    xer_o,
    input  logic               trap_o,
    input  logic               illegal_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!wr_en_o && !cr_we_o && !xer_we_o && !trap_o && !illegal_o && result_o == '0));

    assert_settag_flag_R2: assert property (@(posedge clk) disable iff (rst)
        xer_we_o |-> (xer_o[TAG_LSB] && !wr_en_o && !trap_o));

    assert_dot_with_write_R5: assert property (@(posedge clk) disable iff (rst)
        cr_we_o |-> wr_en_o);

    assert_trap_alone_R6: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> (!wr_en_o && !xer_we_o && !illegal_o));

    assert_illegal_alone_R7: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!wr_en_o && !cr_we_o && !xer_we_o && !trap_o));

    assert_inactive_no_effect_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !tags_active_i) |=> (!wr_en_o && !cr_we_o && !xer_we_o && !trap_o));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!wr_en_o && !cr_we_o && !xer_we_o && !trap_o && !illegal_o));

    assert_single_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en_o, xer_we_o, trap_o, illegal_o}));
endmodule

bind tagx_exec tagx_exec_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .valid_i       (valid_i),
    .tags_active_i (tags_active_i),
    .result_o      (result_o),
    .wr_en_o       (wr_en_o),
    .cr_we_o       (cr_we_o),
    .xer_we_o      (xer_we_o),
    .xer_o         (xer_o),
    .trap_o        (trap_o),
    .illegal_o     (illegal_o)
);

// File: tb/tb_tagx_exec.sv
module tb_tagx_exec;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [31:0] instr_i;
    logic        tags_active_i;
    logic [63:0] xer_i;
    logic [4:0]  ra_addr_o, rb_addr_o;
    logic [63:0] ra_data_i, rb_data_i;
    logic [63:0] result_o;
    logic        wr_en_o;
    logic [4:0]  wr_addr_o;
    logic        cr_we_o;
    logic [3:0]  cr_o;
    logic        xer_we_o;
    logic [63:0] xer_o;
    logic        trap_o;
    logic        illegal_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    tagx_exec dut (.*);

    typedef struct packed {
        logic [4:0]  mn;
        logic [4:0]  fa;
        logic [4:0]  fb;
        logic [4:0]  rt;
        logic [3:0]  k;
        logic [63:0] xer;
        logic [63:0] ra;
        logic [63:0] rb;
        logic [63:0] res;
        logic [3:0]  cr;
    } sv_t;

    localparam logic [63:0] X20 = 64'h0000_0000_0010_0000;
    localparam int NV = 9;
    localparam sv_t VECS [NV] = '{
        '{5'd24, 5'd3,    5'h1E, 5'd1, 4'd11, X20,                  64'd0, 64'd0,  64'd3,                  4'b0000},
        '{5'd25, 5'd3,    5'h1E, 5'd2, 4'd11, 64'd0,                64'd0, 64'd0,  64'hFFFF_FFFF_FFFF_FFFE, 4'b1000},
        '{5'd27, 5'h10,   5'd4,  5'd3, 4'd0,  64'h0000_0000_8000_0000, 64'd0, 64'd5, 64'hFFFF_FFFF_FFFF_FFF0, 4'b1001},
        '{5'd26, 5'h10,   5'd4,  5'd4, 4'd0,  64'd0,                64'd0, 64'd5,  64'd5,                  4'b0000},
        '{5'd29, 5'd9,    5'd7,  5'd5, 4'd11, X20,                  64'd0, 64'd0,  64'd0,                  4'b0010},
        '{5'd28, 5'd9,    5'd7,  5'd6, 4'd11, 64'd0,                64'd123, 64'd0, 64'd7,                 4'b0000},
        '{5'd31, 5'd12,   5'd13, 5'd7, 4'd15, 64'h0000_0000_0001_0000, 64'h1234_5678_9ABC_DEF0, 64'h2A, 64'h1234_5678_9ABC_DEF0, 4'b0100},
        '{5'd30, 5'd12,   5'd13, 5'd8, 4'd15, X20,                  64'h1234_5678_9ABC_DEF0, 64'h2A, 64'h2A, 4'b0000},
        '{5'd31, 5'd14,   5'd15, 5'd9, 4'd4,  64'h0000_0000_8800_0000, 64'hF000_0000_0000_0000, 64'd1, 64'hF000_0000_0000_0000, 4'b1001}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sel_word(input logic [4:0] mn, fa, fb, rt, input logic [3:0] k);
        return {6'd30, fa, rt, fb, k, 2'b00, mn};
    endfunction

    function automatic logic [31:0] trap_word(input logic [3:0] k);
        return {6'd31, 5'd0, 10'd0, k, 6'd36, 1'b0};
    endfunction

    task automatic issue(input logic [31:0] w, input logic ta, input logic [63:0] x,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        valid_i = 1'b1; instr_i = w; tags_active_i = ta; xer_i = x;
        ra_data_i = a; rb_data_i = b;
        #1;
    endtask

    task automatic settle();
        @(negedge clk);
        valid_i = 1'b0; instr_i = '0;
    endtask

    task automatic quiet_check(input string req);
        @(negedge clk);
        chk(req, {59'd0, wr_en_o, cr_we_o, xer_we_o, trap_o, illegal_o}, 64'd0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; valid_i = 1'b0; instr_i = '0; tags_active_i = 1'b1;
        xer_i = '0; ra_data_i = '0; rb_data_i = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 strobes", {59'd0, wr_en_o, cr_we_o, xer_we_o, trap_o, illegal_o}, 64'd0);
        chk("R1 result", result_o, 64'd0);
        rst = 1'b0;

        // R3 R4 R5 table of select vectors
        for (int i = 0; i < NV; i++) begin
            issue(sel_word(VECS[i].mn, VECS[i].fa, VECS[i].fb, VECS[i].rt, VECS[i].k),
                  1'b1, VECS[i].xer, VECS[i].ra, VECS[i].rb);
            chk("R4 ra_addr", {59'd0, ra_addr_o}, {59'd0, VECS[i].fa});
            chk("R4 rb_addr", {59'd0, rb_addr_o}, {59'd0, VECS[i].fb});
            settle();
            chk("R3 result", result_o, VECS[i].res);
            chk("R3 wr_en", {63'd0, wr_en_o}, 64'd1);
            chk("R3 wr_addr", {59'd0, wr_addr_o}, {59'd0, VECS[i].rt});
            chk("R5 cr_we", {63'd0, cr_we_o}, {63'd0, VECS[i].mn[0]});
            if (VECS[i].mn[0]) chk("R5 cr", {60'd0, cr_o}, {60'd0, VECS[i].cr});
            // R9 strobes last one cycle
            quiet_check("R9 strobe clears");
        end

        // R2 set-tag
        issue(32'h7C01_03E6, 1'b1, 64'h1, 64'd0, 64'd0);
        settle();
        chk("R2 xer_we", {63'd0, xer_we_o}, 64'd1);
        chk("R2 xer value", xer_o, 64'h0000_0000_0010_0001);
        chk("R2 no write", {63'd0, wr_en_o}, 64'd0);
        quiet_check("R9 set-tag clears");

        // R6 trap when tag clear, none when set
        issue(trap_word(4'd11), 1'b1, 64'd0, 64'd0, 64'd0);
        settle();
        chk("R6 trap on clear", {63'd0, trap_o}, 64'd1);
        chk("R6 trap no write", {63'd0, wr_en_o}, 64'd0);
        issue(trap_word(4'd11), 1'b1, X20, 64'd0, 64'd0);
        settle();
        chk("R6 no trap on set", {63'd0, trap_o}, 64'd0);
        issue(trap_word(4'd0), 1'b1, 64'h0000_0000_8000_0000, 64'd0, 64'd0);
        settle();
        chk("R6 no trap bit31 set", {63'd0, trap_o}, 64'd0);

        // R7 tags inactive
        issue(32'h7C01_03E6, 1'b0, 64'd0, 64'd0, 64'd0);
        settle();
        chk("R7 settag illegal", {59'd0, wr_en_o, cr_we_o, xer_we_o, trap_o, illegal_o}, 64'd1);
        issue(sel_word(5'd31, 5'd1, 5'd2, 5'd3, 4'd11), 1'b0, X20, 64'd9, 64'd8);
        settle();
        chk("R7 select illegal", {59'd0, wr_en_o, cr_we_o, xer_we_o, trap_o, illegal_o}, 64'd1);
        issue(trap_word(4'd11), 1'b0, 64'd0, 64'd0, 64'd0);
        settle();
        chk("R7 trap illegal", {59'd0, wr_en_o, cr_we_o, xer_we_o, trap_o, illegal_o}, 64'd1);

        // R8 unrelated words and invalid cycles
        issue(32'h7C00_0000, 1'b1, 64'd0, 64'd0, 64'd0);
        settle();
        chk("R8 other word", {59'd0, wr_en_o, cr_we_o, xer_we_o, trap_o, illegal_o}, 64'd0);
        issue(sel_word(5'd23, 5'd1, 5'd2, 5'd3, 4'd11), 1'b0, 64'd0, 64'd0, 64'd0);
        settle();
        chk("R8 minor below range", {59'd0, wr_en_o, cr_we_o, xer_we_o, trap_o, illegal_o}, 64'd0);
        @(negedge clk);
        valid_i = 1'b0; instr_i = 32'h7C01_03E6; tags_active_i = 1'b1;
        @(negedge clk);
        chk("R8 invalid cycle", {59'd0, wr_en_o, cr_we_o, xer_we_o, trap_o, illegal_o}, 64'd0);

        // R1 reset mid-stream clears a pending result
        issue(sel_word(5'd25, 5'd3, 5'd4, 5'd5, 4'd11), 1'b1, 64'd0, 64'd0, 64'd0);
        rst = 1'b1;
        settle();
        chk("R1 reset overrides", {59'd0, wr_en_o, cr_we_o, xer_we_o, trap_o, illegal_o}, 64'd0);
        rst = 1'b0;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule